// File: doc/BRIEF.md
# ADC Sequence Status Flag Unit

This block holds the status word of a multi-channel converter's sequence controller. The word is one 8-bit readable register. It carries three sticky flags and a 4-bit conversion counter. The flags are sequence-complete, external-trigger overrun and result overrun. The flags are set by hardware events from the sequencer and the result path. Software clears them in several ways: by writing 1 to the flag's own bit, as a side effect of writing other control registers, or by reading a result register while fast flag clearing is enabled.

Register bit positions are fixed by behaviour because software decodes them:

| Bit | Content |
|-----|---------|
| 7 | sequence complete |
| 6 | reads 0 |
| 5 | trigger overrun |
| 4 | result overrun |
| 3..0 | conversion counter |

The counter restarts at zero whenever a sequence starts. It advances by one for each finished conversion and wraps at the programmed sequence length. The analog converter, the sequencer state machine, result storage and compare logic all sit outside the block and drive its strobes. Each strobe is high for one clock cycle per event.

Top module: `adc_seq_status`

## Requirements
- R1: Out of synchronous reset `stat_q` is 8'h00, and bit 6 reads 0 at all times.
- R2: A `seq_done` pulse sets bit 7 on the next clock edge. This happens after every sequence, so it also applies in continuous scan operation.
- R3: `stat_wr` with `stat_wdata[7]`=1 clears bit 7. A write with that bit 0 leaves bit 7 unchanged.
- R4: A `start_wr` pulse clears bits 7, 5 and 4 and sets the counter to 0.
- R5: With `fast_clr`=1, a `res_rd` pulse clears bit 7. With `fast_clr`=0, `res_rd` has no effect.
- R6: Bit 5 sets only when `trig_edge` pulses while `edge_mode`=1 (edge-trigger mode) and `seq_busy`=1.
- R7: Bit 4 sets when `res_wr` pulses while `ccf[res_ch]`=1.
- R8: Bits 5 and 4 each clear on `stat_wr` with a 1 in their own data bit. Both also clear on an `abort_wr` pulse. `abort_wr` leaves bit 7 and the counter unchanged.
- R9: Status writes never change the counter bits 3..0, and data bits 6 and 3..0 are ignored.
- R10: Each `conv_done` pulse advances the counter by one. After the counter reaches `seq_len`-1 it returns to 0. `seq_len`=0 means 16. `start_wr` overrides `conv_done` in the same cycle.
- R11: When a hardware set and any clear source hit the same flag in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_busy | input | 1 | A conversion sequence is in progress |
| seq_done | input | 1 | Strobe: sequence finished |
| conv_done | input | 1 | Strobe: one conversion finished |
| seq_len | input | 4 | Conversions per sequence, 0 = 16 |
| edge_mode | input | 1 | 1 = external trigger is edge sensitive |
| trig_edge | input | 1 | Strobe: active external trigger edge |
| res_wr | input | 1 | Strobe: a result register is written |
| res_ch | input | 4 | Channel of the result write |
| ccf | input | 16 | Per-channel conversion-complete flags |
| fast_clr | input | 1 | Fast flag clear mode enable |
| res_rd | input | 1 | Strobe: a result register is read |
| start_wr | input | 1 | Strobe: write to sequence-start register |
| abort_wr | input | 1 | Strobe: write to an abort-class control or compare register |
| stat_wr | input | 1 | Strobe: write to this status register |
| stat_wdata | input | 8 | Status write data |
| stat_q | output | 8 | Status register value |

## Verification
The main collisions are a hardware set landing in the same cycle as a clear of the same flag. The cases covered are:
- `seq_done` together with a 1-write, a fast-clear read or `start_wr`;
- a result overwrite together with `abort_wr`;
- `conv_done` together with `start_wr`.

The bench provokes each pairing on purpose and also through several hundred cycles of random strobes. A behavioural reference model judges every cycle. The model applies set-over-clear for the flags and start-over-increment for the counter.

// File: rtl/adcsf_pkg.sv
package adcsf_pkg;
  localparam int STAT_W   = 8;
  localparam int CNT_W    = 4;
  localparam int SCF_POS  = 7;
  localparam int TOR_POS  = 5;
  localparam int ROR_POS  = 4;
  // bits that are real sticky flags
  localparam logic [STAT_W-1:0] FLAG_MASK =
    (STAT_W'(1) << SCF_POS) | (STAT_W'(1) << TOR_POS) | (STAT_W'(1) << ROR_POS);
  // flags cleared by abort-class writes
  localparam logic [STAT_W-1:0] ABORT_MASK =
    (STAT_W'(1) << TOR_POS) | (STAT_W'(1) << ROR_POS);

  typedef struct packed {
    logic [STAT_W-1:0] set;
    logic [STAT_W-1:0] clr;
  } flag_evt_t;
endpackage

// File: rtl/adcsf_event_decode.sv
module adcsf_event_decode
  import adcsf_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              seq_busy,
  input  logic              seq_done,
  input  logic              edge_mode,
  input  logic              trig_edge,
  input  logic              res_wr,
  input  logic [CH_W-1:0]   res_ch,
  input  logic [NUM_CH-1:0] ccf,
  input  logic              fast_clr,
  input  logic              res_rd,
  input  logic              start_wr,
  input  logic              abort_wr,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  output flag_evt_t         evt
);
  logic tor_hit, ror_hit, fast_hit;

  always_comb begin
    tor_hit  = edge_mode && seq_busy && trig_edge;
    ror_hit  = res_wr && ccf[res_ch];
    fast_hit = fast_clr && res_rd;

    evt.set          = '0;
    evt.set[SCF_POS] = seq_done;
    evt.set[TOR_POS] = tor_hit;
    evt.set[ROR_POS] = ror_hit;

    evt.clr = ({STAT_W{stat_wr}} & stat_wdata)
            | ({STAT_W{abort_wr}} & ABORT_MASK)
            | ({STAT_W{start_wr}} & FLAG_MASK);
    evt.clr[SCF_POS] = evt.clr[SCF_POS] | fast_hit;
  end
endmodule

// File: rtl/adcsf_flag_reg.sv
module adcsf_flag_reg
  import adcsf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  flag_evt_t         evt,
  output logic [STAT_W-1:0] flag_q
);
  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (FLAG_MASK[i]) begin : g_flop
      logic q;
      always_ff @(posedge clk) begin
        if (rst)             q <= 1'b0;
        else if (evt.set[i]) q <= 1'b1;   // set wins over clear
        else if (evt.clr[i]) q <= 1'b0;
      end
      assign flag_q[i] = q;
    end else begin : g_zero
      assign flag_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/adcsf_conv_counter.sv
module adcsf_conv_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_wr,
  input  logic         conv_done,
  input  logic [W-1:0] seq_len,
  output logic [W-1:0] cnt_q
);
  logic [W:0] limit;
  logic [W:0] inc;

  always_comb begin
    limit = (seq_len == '0) ? (W+1)'(1) << W : {1'b0, seq_len};
    inc   = {1'b0, cnt_q} + (W+1)'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (start_wr)      cnt_q <= '0;
    else if (conv_done)     cnt_q <= (inc == limit) ? '0 : inc[W-1:0];
  end
endmodule

// File: rtl/adc_seq_status.sv
module adc_seq_status
  import adcsf_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seq_busy,
  input  logic              seq_done,
  input  logic              conv_done,
  input  logic [CNT_W-1:0]  seq_len,
  input  logic              edge_mode,
  input  logic              trig_edge,
  input  logic              res_wr,
  input  logic [CH_W-1:0]   res_ch,
  input  logic [NUM_CH-1:0] ccf,
  input  logic              fast_clr,
  input  logic              res_rd,
  input  logic              start_wr,
  input  logic              abort_wr,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  output logic [STAT_W-1:0] stat_q
);
  flag_evt_t          evt;
  logic [STAT_W-1:0]  flag_q;
  logic [CNT_W-1:0]   cnt_q;

  adcsf_event_decode #(.NUM_CH(NUM_CH)) u_dec (
    .seq_busy   (seq_busy),
    .seq_done   (seq_done),
    .edge_mode  (edge_mode),
    .trig_edge  (trig_edge),
    .res_wr     (res_wr),
    .res_ch     (res_ch),
    .ccf        (ccf),
    .fast_clr   (fast_clr),
    .res_rd     (res_rd),
    .start_wr   (start_wr),
    .abort_wr   (abort_wr),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .evt        (evt)
  );

  adcsf_flag_reg u_flags (
    .clk    (clk),
    .rst    (rst),
    .evt    (evt),
    .flag_q (flag_q)
  );

  adcsf_conv_counter #(.W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .start_wr  (start_wr),
    .conv_done (conv_done),
    .seq_len   (seq_len),
    .cnt_q     (cnt_q)
  );

  assign stat_q = flag_q | {{(STAT_W-CNT_W){1'b0}}, cnt_q};
endmodule

// File: rtl/adc_seq_status_chk.sv
module adc_seq_status_chk
  import adcsf_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              seq_busy,
  input logic              seq_done,
  input logic              conv_done,
  input logic              edge_mode,
  input logic              trig_edge,
  input logic              res_wr,
  input logic [CH_W-1:0]   res_ch,
  input logic [NUM_CH-1:0] ccf,
  input logic              fast_clr,
  input logic              res_rd,
  input logic              start_wr,
  input logic              abort_wr,
  input logic              stat_wr,
  input logic [STAT_W-1:0] stat_q
);
  // R2 / R11: completion always lands, whatever clears arrive with it
  a_r2_done_sets: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> stat_q[SCF_POS]);

  // R4: sequence start zeroes the counter
  a_r4_start_zero_cnt: assert property (@(posedge clk) disable iff (rst)
    start_wr |=> stat_q[CNT_W-1:0] == '0);

  // R4: sequence start clears completion unless set simultaneously
  a_r4_start_clr_scf: assert property (@(posedge clk) disable iff (rst)
    start_wr && !seq_done |=> !stat_q[SCF_POS]);

  // R5: fast-clear read removes completion
  a_r5_fast_read: assert property (@(posedge clk) disable iff (rst)
    fast_clr && res_rd && !seq_done |=> !stat_q[SCF_POS]);

  // R6: qualified trigger edge flags overrun
  a_r6_trig_overrun: assert property (@(posedge clk) disable iff (rst)
    edge_mode && seq_busy && trig_edge |=> stat_q[TOR_POS]);

  // R7: overwrite of an unread result flags overrun
  a_r7_result_overrun: assert property (@(posedge clk) disable iff (rst)
    res_wr && ccf[res_ch] |=> stat_q[ROR_POS]);

  // R8: abort clears the trigger overrun flag when no new edge arrives
  a_r8_abort_tor: assert property (@(posedge clk) disable iff (rst)
    abort_wr && !(edge_mode && seq_busy && trig_edge) |=> !stat_q[TOR_POS]);

  // R9: status writes leave the counter alone
  a_r9_cnt_untouched: assert property (@(posedge clk) disable iff (rst)
    stat_wr && !start_wr && !conv_done |=> $stable(stat_q[CNT_W-1:0]));
endmodule

bind adc_seq_status adc_seq_status_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .seq_busy  (seq_busy),
  .seq_done  (seq_done),
  .conv_done (conv_done),
  .edge_mode (edge_mode),
  .trig_edge (trig_edge),
  .res_wr    (res_wr),
  .res_ch    (res_ch),
  .ccf       (ccf),
  .fast_clr  (fast_clr),
  .res_rd    (res_rd),
  .start_wr  (start_wr),
  .abort_wr  (abort_wr),
  .stat_wr   (stat_wr),
  .stat_q    (stat_q)
);

// File: tb/tb_adc_seq_status.sv
`timescale 1ns/1ps
module tb_adc_seq_status;
  localparam int NCH = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        seq_busy, seq_done, conv_done;
  logic [3:0]  seq_len;
  logic        edge_mode, trig_edge, res_wr;
  logic [3:0]  res_ch;
  logic [15:0] ccf;
  logic        fast_clr, res_rd, start_wr, abort_wr, stat_wr;
  logic [7:0]  stat_wdata;
  logic [7:0]  stat_q;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  bit m_scf, m_tor, m_ror;
  int m_cnt;

  always #4 clk = ~clk;   // 125 MHz

  adc_seq_status #(.NUM_CH(NCH)) dut (
    .clk(clk), .rst(rst), .seq_busy(seq_busy), .seq_done(seq_done),
    .conv_done(conv_done), .seq_len(seq_len), .edge_mode(edge_mode),
    .trig_edge(trig_edge), .res_wr(res_wr), .res_ch(res_ch), .ccf(ccf),
    .fast_clr(fast_clr), .res_rd(res_rd), .start_wr(start_wr),
    .abort_wr(abort_wr), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .stat_q(stat_q)
  );

  function automatic logic [7:0] model_word();
    return {m_scf, 1'b0, m_tor, m_ror, 4'(m_cnt)};
  endfunction

  task automatic model_step();
    bit s_scf, c_scf, s_tor, c_tor, s_ror, c_ror;
    int len;
    if (rst) begin
      m_scf = 0; m_tor = 0; m_ror = 0; m_cnt = 0;
      return;
    end
    s_scf = seq_done;
    c_scf = start_wr || (stat_wr && stat_wdata[7]) || (fast_clr && res_rd);
    s_tor = edge_mode && seq_busy && trig_edge;
    c_tor = start_wr || abort_wr || (stat_wr && stat_wdata[5]);
    s_ror = res_wr && ccf[res_ch];
    c_ror = start_wr || abort_wr || (stat_wr && stat_wdata[4]);
    m_scf = s_scf ? 1 : (c_scf ? 0 : m_scf);
    m_tor = s_tor ? 1 : (c_tor ? 0 : m_tor);
    m_ror = s_ror ? 1 : (c_ror ? 0 : m_ror);
    len = (seq_len == 0) ? 16 : int'(seq_len);
    if (start_wr) m_cnt = 0;
    else if (conv_done) m_cnt = (m_cnt == len - 1) ? 0 : (m_cnt + 1) % 16;
  endtask

  task automatic strobes_off();
    seq_done = 0; conv_done = 0; trig_edge = 0; res_wr = 0;
    res_rd = 0; start_wr = 0; abort_wr = 0; stat_wr = 0; stat_wdata = 8'h00;
  endtask

  // one clock: model follows the edge, compare at the falling edge
  task automatic cyc(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    checks++;
    if (stat_q !== model_word()) begin
      errors++;
      $display("FAIL %s: stat_q actual %02h expected %02h", tag, stat_q, model_word());
    end
    strobes_off();
  endtask

  task automatic expect_word(input string tag, input logic [7:0] exp);
    checks++;
    if (stat_q !== exp) begin
      errors++;
      $display("FAIL %s: stat_q actual %02h expected %02h", tag, stat_q, exp);
    end
  endtask

  initial begin
    rst = 1; seq_busy = 0; seq_len = 4'd4; edge_mode = 0; res_ch = 0;
    ccf = '0; fast_clr = 0;
    strobes_off();
    @(negedge clk);
    cyc("R1 reset");
    cyc("R1 reset");
    expect_word("R1 reset value", 8'h00);
    rst = 0;

    // R10 counter wrap at 4
    for (int i = 0; i < 5; i++) begin conv_done = 1; cyc("R10 count"); end
    expect_word("R10 wrap len4", 8'h01);

    // R2 completion, R3 zero write, R9 counter bits ignored
    seq_done = 1; cyc("R2 set");
    expect_word("R2 flag", 8'h81);
    stat_wr = 1; stat_wdata = 8'h00; cyc("R3 zero write");
    stat_wr = 1; stat_wdata = 8'h4F; cyc("R9 cnt write");
    expect_word("R9 counter kept", 8'h81);
    stat_wr = 1; stat_wdata = 8'h80; cyc("R3 w1c");
    expect_word("R3 cleared", 8'h01);

    // R5 fast clear
    seq_done = 1; cyc("R2 set again");
    res_rd = 1; cyc("R5 read no fast");
    expect_word("R5 no fast keeps", 8'h81);
    fast_clr = 1; res_rd = 1; cyc("R5 fast read");
    expect_word("R5 fast clears", 8'h01);
    fast_clr = 0;

    // R6 trigger overrun qualification
    seq_busy = 1; edge_mode = 0; trig_edge = 1; cyc("R6 level mode");
    seq_busy = 0; edge_mode = 1; trig_edge = 1; cyc("R6 idle");
    expect_word("R6 no set", 8'h01);
    seq_busy = 1; trig_edge = 1; cyc("R6 edge busy");
    expect_word("R6 set", 8'h21);
    stat_wr = 1; stat_wdata = 8'h20; cyc("R8 w1c tor");
    expect_word("R8 tor cleared", 8'h01);

    // R7 result overrun
    res_ch = 4'd3; ccf = 16'h0004; res_wr = 1; cyc("R7 ccf clear");
    expect_word("R7 no set", 8'h01);
    ccf = 16'h0008; res_wr = 1; cyc("R7 overwrite");
    trig_edge = 1; cyc("R6 set again");
    expect_word("R7 both flags", 8'h31);
    seq_done = 1; cyc("R2 set");
    abort_wr = 1; cyc("R8 abort");
    expect_word("R8 abort keeps scf cnt", 8'h81);
    res_wr = 1; cyc("R7 set");
    stat_wr = 1; stat_wdata = 8'h10; cyc("R8 w1c ror");
    expect_word("R8 ror cleared", 8'h81);

    // R4 start clears all
    conv_done = 1; cyc("R10 count");
    trig_edge = 1; res_wr = 1; cyc("R6 R7 set");
    start_wr = 1; cyc("R4 start");
    expect_word("R4 all clear", 8'h00);

    // R11 collisions
    seq_done = 1; stat_wr = 1; stat_wdata = 8'hB0; cyc("R11 done vs w1c");
    expect_word("R11 scf wins w1c", 8'h80);
    seq_done = 1; fast_clr = 1; res_rd = 1; cyc("R11 done vs fast");
    fast_clr = 0;
    seq_done = 1; start_wr = 1; conv_done = 1; cyc("R11 done vs start");
    expect_word("R11 R10 start beats count", 8'h80);
    res_wr = 1; abort_wr = 1; cyc("R11 ror vs abort");
    trig_edge = 1; stat_wr = 1; stat_wdata = 8'h20; cyc("R11 tor vs w1c");
    expect_word("R11 set wins", 8'hB0);

    // R10 length 0 means 16
    start_wr = 1; cyc("R4 start");
    seq_len = 4'd0;
    for (int i = 0; i < 15; i++) begin conv_done = 1; cyc("R10 len16"); end
    expect_word("R10 reaches 15", 8'h0F);
    conv_done = 1; cyc("R10 len16 wrap");
    expect_word("R10 wrap to 0", 8'h00);

    // random traffic, model judges every cycle
    seq_len = 4'd6;
    start_wr = 1; cyc("R4 start");
    for (int i = 0; i < 600; i++) begin
      seq_busy   = 1'($urandom);
      edge_mode  = 1'($urandom);
      fast_clr   = 1'($urandom);
      ccf        = 16'($urandom);
      res_ch     = 4'($urandom);
      seq_done   = ($urandom % 6) == 0;
      conv_done  = ($urandom % 3) == 0;
      trig_edge  = ($urandom % 4) == 0;
      res_wr     = ($urandom % 4) == 0;
      res_rd     = ($urandom % 5) == 0;
      start_wr   = ($urandom % 23) == 0;
      abort_wr   = ($urandom % 13) == 0;
      stat_wr    = ($urandom % 5) == 0;
      stat_wdata = 8'($urandom);
      cyc("R11 random");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule